// File: doc/BRIEF.md
# Triple Interval Timer with Compare and Wrap Events

This peripheral holds three independent 32-bit counters behind one word-wide register port. Each counter has a live count, a reload value and two compare values. A counter advances by one step per qualifying tick, either upward or downward. When it passes its end of range it reloads from its reload value and can raise a wrap event. An upward counter preloaded with all-ones minus (period - 1) therefore wraps once every period ticks, which gives a periodic interrupt source. A second counter left running freely serves as a readable time base.

Nine event sources share one status register: two compare hits and one wrap per counter. Status bits are sticky. A mask register selects which of them drive a single registered interrupt line. One shared control word holds, for each counter, its run enable, tick source, wrap-event enable and count direction. Ticks are one-cycle enables on an internal and an external input. Only word-aligned byte addresses decode.

Top module: `tmr3_unit`

## Requirements
- R1: Synchronous active-high reset clears every count, reload, compare, control, status and mask register, `irq` and `rdata` to zero.
- R2: Counter g (g = 0..2) owns byte addresses 0x10*g + {0x0 count, 0x4 reload, 0x8 compare A, 0xC compare B}. Control is at 0x30 (12 bits), status at 0x34 (9 bits) and mask at 0x38 (9 bits). All of them read back what was written, zero-extended.
- R3: Counter g advances only on a clock where its run bit (control bit 3g) is 1 and its selected tick is high. Otherwise it holds its value.
- R4: Control bit 3g+1 selects the tick: 0 takes `tick_int` and 1 takes `tick_ext`. The other tick input has no effect.
- R5: Control bit 9+g set to 1 makes counter g count up. Advancing from 0xFFFFFFFF loads the reload value and sets status bit 3g+2, so a reload of L gives one wrap every 2^32 - L ticks.
- R6: Control bit 9+g set to 0 makes counter g count down. Advancing from 0 loads the reload value and flags a wrap in the same way.
- R7: When an advance produces a count equal to compare A, status bit 3g is set. When it equals compare B, status bit 3g+1 is set.
- R8: With control bit 3g+2 at 0, a wrap still reloads the count but leaves status bit 3g+2 unchanged.
- R9: Status bits are sticky. A status write clears each bit whose written value is 0 and keeps each bit written as 1; it never sets a bit. An event in the same cycle as a clearing write leaves its bit set.
- R10: `irq` is 1 exactly one clock after a cycle in which some status bit is 1 with its mask bit at 0. A mask bit of 1 blocks its source.
- R11: A write to a count register loads the written value, even while the counter runs. In that cycle it takes priority over an advance and raises no event.
- R12: `rdata` shows, one clock after `addr` is presented, the register selected. Unmapped or misaligned addresses read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_int | input | 1 | Internal one-cycle tick enable |
| tick_ext | input | 1 | External one-cycle tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bound checker watches four rules on every clock. It checks that the interrupt line follows unmasked status one cycle later and that status bits never drop without a status write. It checks that no count moves in a cycle with no tick and no write. It checks that a wrap status bit only rises when that counter's wrap enable was set. Reload values, end-of-range periods in both directions, compare hits, tick-source selection, write priority over a running counter and the register map itself need concrete sequences, so the bench's scenarios are what show them.

// File: rtl/tmr3_pkg.sv
`timescale 1ns/1ps
package tmr3_pkg;
  // register slot inside one counter's 16-byte window
  typedef enum logic [1:0] {
    SLOT_COUNT = 2'd0,
    SLOT_RELOAD = 2'd1,
    SLOT_CMP_A = 2'd2,
    SLOT_CMP_B = 2'd3
  } slot_e;

  localparam int EVT_PER_CH = 3;
  localparam int EV_CMP_A = 0;
  localparam int EV_CMP_B = 1;
  localparam int EV_WRAP = 2;

  typedef struct packed {
    logic up;    // count direction, 1 = up
    logic wie;   // wrap event enable
    logic sel;   // tick source, 1 = external
    logic run;   // run enable
  } chctl_t;
endpackage

// File: rtl/tmr3_channel.sv
`timescale 1ns/1ps
module tmr3_channel
  import tmr3_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  chctl_t                ctl,
  input  logic                  tick_int,
  input  logic                  tick_ext,
  input  logic                  wr,
  input  slot_e                 wr_slot,
  input  logic [W-1:0]          wdata,
  input  slot_e                 rd_slot,
  output logic [W-1:0]          rd_val,
  output logic [W-1:0]          cnt_o,
  output logic [EVT_PER_CH-1:0] evt
);
  logic [W-1:0] cnt_q, rel_q, cmpa_q, cmpb_q;
  logic [W-1:0] step;
  logic         tick_sel, adv, at_end, cnt_wr;

  always_comb begin
    tick_sel = ctl.sel ? tick_ext : tick_int;
    cnt_wr   = wr && (wr_slot == SLOT_COUNT);
    adv      = ctl.run && tick_sel && !cnt_wr;
    at_end   = ctl.up ? (&cnt_q) : (cnt_q == '0);
    if (at_end)      step = rel_q;
    else if (ctl.up) step = cnt_q + W'(1);
    else             step = cnt_q - W'(1);
    evt[EV_CMP_A] = adv && (step == cmpa_q);
    evt[EV_CMP_B] = adv && (step == cmpb_q);
    evt[EV_WRAP]  = adv && at_end && ctl.wie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (cnt_wr)   cnt_q <= wdata;
      else if (adv) cnt_q <= step;
      if (wr && wr_slot == SLOT_RELOAD) rel_q  <= wdata;
      if (wr && wr_slot == SLOT_CMP_A)  cmpa_q <= wdata;
      if (wr && wr_slot == SLOT_CMP_B)  cmpb_q <= wdata;
    end
  end

  always_comb begin
    unique case (rd_slot)
      SLOT_COUNT:  rd_val = cnt_q;
      SLOT_RELOAD: rd_val = rel_q;
      SLOT_CMP_A:  rd_val = cmpa_q;
      default:     rd_val = cmpb_q;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr3_events.sv
`timescale 1ns/1ps
module tmr3_events #(
  parameter int EVW = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] evt,
  input  logic           wr_status,
  input  logic           wr_mask,
  input  logic [EVW-1:0] wdata,
  output logic [EVW-1:0] status_o,
  output logic [EVW-1:0] mask_o,
  output logic           irq_o
);
  logic [EVW-1:0] status_q, mask_q, status_d;
  logic           irq_q;

  always_comb begin
    status_d = (wr_status ? (status_q & wdata) : status_q) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (wr_mask) mask_q <= wdata;
      irq_q    <= |(status_q & ~mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/tmr3_unit.sv
`timescale 1ns/1ps
module tmr3_unit
  import tmr3_pkg::*;
#(
  parameter int N = 3,
  parameter int W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_int,
  input  logic              tick_ext,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq
);
  localparam int EVW = EVT_PER_CH * N;
  localparam int CTW = 4 * N;
  localparam int WIDX_W = ADDR_W - 2;
  localparam int GRP_W = WIDX_W - 2;
  localparam int CTRL_IDX = 4 * N;
  localparam int STAT_IDX = 4 * N + 1;
  localparam int MASK_IDX = 4 * N + 2;

  logic [WIDX_W-1:0] widx;
  logic [GRP_W-1:0]  grp;
  logic              aligned, wr_hit;
  logic [CTW-1:0]    ctl_q;
  logic [EVW-1:0]    evt_flat, status_q, mask_q;
  logic [N*W-1:0]    cnt_flat;
  logic [W-1:0]      ch_rd [N];
  logic [W-1:0]      rd_mux;
  chctl_t            ch_ctl [N];

  assign widx    = addr[ADDR_W-1:2];
  assign grp     = widx[WIDX_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_hit  = wr_en && aligned;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (wr_hit && widx == WIDX_W'(CTRL_IDX)) ctl_q <= wdata[CTW-1:0];
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    assign ch_ctl[g] = '{up:  ctl_q[EVW + g],
                         wie: ctl_q[EVT_PER_CH*g + 2],
                         sel: ctl_q[EVT_PER_CH*g + 1],
                         run: ctl_q[EVT_PER_CH*g]};
    tmr3_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ch_ctl[g]),
      .tick_int (tick_int),
      .tick_ext (tick_ext),
      .wr       (wr_hit && grp == GRP_W'(g)),
      .wr_slot  (slot_e'(widx[1:0])),
      .wdata    (wdata),
      .rd_slot  (slot_e'(widx[1:0])),
      .rd_val   (ch_rd[g]),
      .cnt_o    (cnt_flat[g*W +: W]),
      .evt      (evt_flat[EVT_PER_CH*g +: EVT_PER_CH])
    );
  end

  tmr3_events #(.EVW(EVW)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt_flat),
    .wr_status (wr_hit && widx == WIDX_W'(STAT_IDX)),
    .wr_mask   (wr_hit && widx == WIDX_W'(MASK_IDX)),
    .wdata     (wdata[EVW-1:0]),
    .status_o  (status_q),
    .mask_o    (mask_q),
    .irq_o     (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N; i++) begin
      if (grp == GRP_W'(i)) rd_mux = ch_rd[i];
    end
    if (widx == WIDX_W'(CTRL_IDX)) rd_mux = {{(W-CTW){1'b0}}, ctl_q};
    if (widx == WIDX_W'(STAT_IDX)) rd_mux = {{(W-EVW){1'b0}}, status_q};
    if (widx == WIDX_W'(MASK_IDX)) rd_mux = {{(W-EVW){1'b0}}, mask_q};
    if (!aligned) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr3_unit_chk.sv
`timescale 1ns/1ps
module tmr3_unit_chk #(
  parameter int N = 3,
  parameter int W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_int,
  input logic              tick_ext,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      rdata,
  input logic              irq,
  input logic [3*N-1:0]    status,
  input logic [3*N-1:0]    mask,
  input logic [4*N-1:0]    ctrl,
  input logic [N*W-1:0]    cnt_flat
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4 * (4 * N + 1));

  logic wr_status;
  assign wr_status = wr_en && (addr == STAT_ADDR);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq && rdata == '0 && status == '0));

  assert_irq_raise_R10: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~mask)) |=> irq);

  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (rst)
    ((status & ~mask) == '0) |=> !irq);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_status |=> ((status & $past(status)) == $past(status)));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick_int && !tick_ext && !wr_en) |=> $stable(cnt_flat));

  for (genvar g = 0; g < N; g++) begin : g_wrap
    assert_wrap_gated_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(status[3*g+2]) |-> $past(ctrl[3*g+2]));
  end
endmodule

bind tmr3_unit tmr3_unit_chk #(.N(N), .W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_int (tick_int),
  .tick_ext (tick_ext),
  .wr_en    (wr_en),
  .addr     (addr),
  .rdata    (rdata),
  .irq      (irq),
  .status   (status_q),
  .mask     (mask_q),
  .ctrl     (ctl_q),
  .cnt_flat (cnt_flat)
);

// File: tb/tmr3_unit_bench.sv
`timescale 1ns/1ps
module tmr3_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_int = 1'b0;
  logic        tick_ext = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          tests = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  tmr3_unit u_tmr3_unit (
    .clk(clk), .rst(rst), .tick_int(tick_int), .tick_ext(tick_ext),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {is_read, byte address, data or expected value}
  localparam logic [38:0] VEC [14] = '{
    {1'b0, 6'h04, 32'h12345678},  // R2 reload of counter 0
    {1'b1, 6'h04, 32'h12345678},
    {1'b0, 6'h18, 32'h0000A5A5},  // R2 compare A of counter 1
    {1'b1, 6'h18, 32'h0000A5A5},
    {1'b0, 6'h38, 32'hFFFFFFFF},  // R2 mask keeps 9 bits
    {1'b1, 6'h38, 32'h000001FF},
    {1'b0, 6'h30, 32'hFFFFFFFF},  // R2 control keeps 12 bits
    {1'b1, 6'h30, 32'h00000FFF},
    {1'b0, 6'h30, 32'h00000000},
    {1'b1, 6'h3C, 32'h00000000},  // R12 unmapped reads zero
    {1'b0, 6'h20, 32'h00000007},  // R11 direct count write
    {1'b1, 6'h20, 32'h00000007},
    {1'b0, 6'h25, 32'hDEADBEEF},  // R12 misaligned write ignored
    {1'b1, 6'h24, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic ext);
    @(negedge clk);
    if (ext) tick_ext = 1'b1; else tick_int = 1'b1;
    @(negedge clk);
    tick_ext = 1'b0; tick_int = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd("R1 count0", 6'h00, 32'h0);
    rd("R1 ctrl", 6'h30, 32'h0);
    rd("R1 status", 6'h34, 32'h0);
    rd("R1 mask", 6'h38, 32'h0);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][38]) rd("R2/R11/R12 table", VEC[i][37:32], VEC[i][31:0]);
      else            wr(VEC[i][37:32], VEC[i][31:0]);
    end

    // R3 up counting on internal tick
    wr(6'h30, 32'h201); wr(6'h00, 32'd10);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    rd("R3 three ticks", 6'h00, 32'd13);
    pulse(1'b1);
    rd("R4 ext tick ignored", 6'h00, 32'd13);
    wr(6'h30, 32'h200); pulse(1'b0);
    rd("R3 stopped holds", 6'h00, 32'd13);
    // R4 external tick source
    wr(6'h30, 32'h203);
    pulse(1'b0);
    rd("R4 int tick ignored", 6'h00, 32'd13);
    pulse(1'b1);
    rd("R4 ext tick counts", 6'h00, 32'd14);

    // R5 up wrap reload and flag
    wr(6'h34, 32'h0); wr(6'h30, 32'h205);
    wr(6'h04, 32'h100); wr(6'h00, 32'hFFFFFFFE);
    pulse(1'b0);
    rd("R5 at top", 6'h00, 32'hFFFFFFFF);
    rd("R5 no flag yet", 6'h34, 32'h0);
    pulse(1'b0);
    rd("R5 reloaded", 6'h00, 32'h100);
    rd("R5 wrap flag", 6'h34, 32'h4);
    // R5 period of 2^32 - L ticks with L = 0xFFFFFFFD
    wr(6'h34, 32'h0); wr(6'h04, 32'hFFFFFFFD); wr(6'h00, 32'hFFFFFFFD);
    pulse(1'b0); pulse(1'b0);
    rd("R5 period not yet", 6'h34, 32'h0);
    pulse(1'b0);
    rd("R5 period third tick", 6'h34, 32'h4);

    // R8 wrap without event enable
    wr(6'h34, 32'h0); wr(6'h30, 32'h201); wr(6'h00, 32'hFFFFFFFF);
    pulse(1'b0);
    rd("R8 reload still", 6'h00, 32'hFFFFFFFD);
    rd("R8 no flag", 6'h34, 32'h0);

    // R6 down counting on counter 1 (compare B is 0 -> R7 hit)
    wr(6'h30, 32'h28); wr(6'h14, 32'd5); wr(6'h10, 32'd1);
    pulse(1'b0);
    rd("R6 down step", 6'h10, 32'd0);
    rd("R7 compare B hit", 6'h34, 32'h10);
    pulse(1'b0);
    rd("R6 down reload", 6'h10, 32'd5);
    rd("R6 down wrap flag", 6'h34, 32'h30);

    // R7 compare A on counter 2
    wr(6'h34, 32'h0); wr(6'h30, 32'h840);
    wr(6'h28, 32'h20); wr(6'h20, 32'h1E);
    pulse(1'b0);
    rd("R7 no hit yet", 6'h34, 32'h0);
    pulse(1'b0);
    rd("R7 compare A hit", 6'h34, 32'h40);

    // R9 sticky status
    wr(6'h34, 32'hFFFFFFFF);
    rd("R9 ones keep", 6'h34, 32'h40);
    wr(6'h34, 32'h0);
    rd("R9 zero clears", 6'h34, 32'h0);
    wr(6'h20, 32'h1F);
    @(negedge clk);
    tick_int = 1'b1; wr_en = 1'b1; addr = 6'h34; wdata = 32'h0;
    @(negedge clk);
    tick_int = 1'b0; wr_en = 1'b0;
    rd("R9 event beats clear", 6'h34, 32'h40);

    // R10 mask and interrupt timing
    chk("R10 masked", {31'b0, irq}, 32'h0);
    wr(6'h38, 32'h1BF);
    chk("R10 lag after unmask", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 raised", {31'b0, irq}, 32'h1);
    wr(6'h34, 32'h0);
    chk("R10 lag after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 dropped", {31'b0, irq}, 32'h0);

    // R11 count write beats a tick
    @(negedge clk);
    tick_int = 1'b1; wr_en = 1'b1; addr = 6'h20; wdata = 32'h50;
    @(negedge clk);
    tick_int = 1'b0; wr_en = 1'b0;
    rd("R11 write priority", 6'h20, 32'h50);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd("R1 count2 after reset", 6'h20, 32'h0);
    rd("R1 mask after reset", 6'h38, 32'h0);

    finish_run();
  end
endmodule